// File: doc/BRIEF.md
# Bus Target Address Window with Remap

This block decides whether an address arriving on the target side of a 32-bit bus bridge falls inside one programmable window, and forms the matching local-side address. The window is described by four registers: a bus-side base with a space-enable bit, a per-bit range mask, a remap value and a free-form region descriptor. The range mask chooses which upper address bits take part in the compare. A hit needs those bits to match the base and needs the space to be enabled.

The translated address keeps every address bit that the mask leaves out. It takes every bit that the mask selects from the remap register. Software sizes the window with the usual probe: it writes all ones to the base and reads it back. Base bits outside the mask read as zero, so the readback shows the window size. Software then writes the chosen base. The range, remap and descriptor registers are loaded during initialization and may be rewritten before traffic starts.

Lookups flow in on a valid/ready channel, and results flow out on a second valid/ready channel through a single register stage. The input is accepted when `lk_valid` and `lk_ready` are both high. `lk_ready` is high whenever the result register is empty or the consumer takes its content in the same cycle. While `rs_valid` is high and `rs_ready` is low, the result stays stable and no new lookup is accepted. The register port is plain: a write strobe, a select and a combinational read.

Top module: `addr_window_xlate`

## Requirements
- R1: Reset (active-low `rst_n`) clears all four registers and the result stage to 0, so `rs_valid` is 0 and every register reads 0.
- R2: When `reg_wr` is high on a clock edge, the register chosen by `reg_sel` is written (0 = base, 1 = range mask, 2 = remap, 3 = descriptor). `reg_rdata` shows the selected register combinationally. Range, remap and descriptor read back all 32 bits as written.
- R3: A base write stores address bits 31:4 only where the range mask bit is 1. Base readback returns 0 in bits 31:4 wherever the current mask bit is 0, 0 in bits 3:2 and 0 in bit 0 (memory space). Bit 1 returns the space-enable bit. Writing all ones with mask 0xFFFF0000 therefore reads back 0xFFFF0002.
- R4: With the space enabled, a lookup hits exactly when its bits 31:4 equal the base's bits 31:4 at every position where the mask bit is 1.
- R5: With the space-enable bit (base bit 1) at 0, no lookup hits.
- R6: Each result carries a local address. Bits 31:4 come from remap where the mask bit is 1 and from the lookup address where it is 0. Bits 3:0 always come from the lookup address. This holds for hits and misses alike.
- R7: A lookup accepted on a clock edge appears on `rs_valid`, `rs_hit` and `rs_laddr` from that edge on. `rs_valid` falls after an edge where the result is taken and no new lookup is accepted.
- R8: `lk_ready` equals `!rs_valid || rs_ready`. While `rs_valid` is high and `rs_ready` is low, `rs_hit` and `rs_laddr` hold their values.
- R9: A lookup is evaluated with the register values in place before the edge that accepts it. Later register writes do not alter a result already held.
- R10: With the space enabled and mask bits 31:4 all 0, every lookup hits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 base, 1 range, 2 remap, 3 descriptor |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register read data |
| lk_valid | input | 1 | Lookup address valid |
| lk_ready | output | 1 | Lookup accepted when high with `lk_valid` |
| lk_addr | input | 32 | Bus-side address to decode |
| rs_valid | output | 1 | Result valid |
| rs_ready | input | 1 | Consumer takes the result |
| rs_hit | output | 1 | Address falls in the enabled window |
| rs_laddr | output | 32 | Translated local address |

## Verification
The assertions check on every cycle the handshake rules: a held result stays stable under back-pressure, `lk_ready` is high whenever the stage is empty, and an accepted lookup yields a valid result on the next edge. They also check that a disabled space never produces a hit, that an all-zero mask with the space enabled always hits, that an address differing from the base in a masked bit misses, that the low four address bits pass through, and that base readback is zero outside the mask. The exact values show up only in the bench's scenarios, checked against a behavioural model: the sizing readback, the remapped address for chosen patterns, and the point at which a register write takes effect relative to a stalled result.

// File: rtl/aw_pkg.sv
package aw_pkg;
  typedef enum logic [1:0] {
    SEL_BASE  = 2'd0,
    SEL_RANGE = 2'd1,
    SEL_REMAP = 2'd2,
    SEL_DESC  = 2'd3
  } aw_sel_e;
endpackage

// File: rtl/aw_regs.sv
module aw_regs #(
  parameter int AW      = 32,
  parameter int DEC_LSB = 4,
  parameter int EN_BIT  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [1:0]            sel,
  input  logic [AW-1:0]         wdata,
  output logic [AW-1:0]         rdata,
  output logic [AW-1:DEC_LSB]   base_q,
  output logic                  base_en,
  output logic [AW-1:0]         range_q,
  output logic [AW-1:0]         remap_q
);
  import aw_pkg::*;

  logic [AW-1:0]       desc_q;
  logic [DEC_LSB-1:0]  base_lo;
  logic [AW-1:0]       base_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      base_en <= 1'b0;
      range_q <= '0;
      remap_q <= '0;
      desc_q  <= '0;
    end else if (wr_en) begin
      unique case (aw_sel_e'(sel))
        SEL_BASE: begin
          base_q  <= wdata[AW-1:DEC_LSB] & range_q[AW-1:DEC_LSB];
          base_en <= wdata[EN_BIT];
        end
        SEL_RANGE: range_q <= wdata;
        SEL_REMAP: remap_q <= wdata;
        SEL_DESC:  desc_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    base_lo         = '0;
    base_lo[EN_BIT] = base_en;
    base_rd         = {base_q & range_q[AW-1:DEC_LSB], base_lo};
  end

  always_comb begin
    unique case (aw_sel_e'(sel))
      SEL_BASE:  rdata = base_rd;
      SEL_RANGE: rdata = range_q;
      SEL_REMAP: rdata = remap_q;
      SEL_DESC:  rdata = desc_q;
      default:   rdata = '0;
    endcase
  end

  // R3: probe readback never shows bits outside the mask, and the space bit reads 0
  assert_base_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'd0) |-> (((rdata[AW-1:DEC_LSB] & ~range_q[AW-1:DEC_LSB]) == '0) && !rdata[0]));

  // R3: a base write leaves no stored bit outside the mask in force at the write
  assert_base_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 2'd0) |=> ((base_q & ~$past(range_q[AW-1:DEC_LSB])) == '0));
endmodule

// File: rtl/aw_match.sv
module aw_match #(
  parameter int AW      = 32,
  parameter int DEC_LSB = 4
) (
  input  logic [AW-1:0]       addr,
  input  logic [AW-1:DEC_LSB] base,
  input  logic                en,
  input  logic [AW-1:0]       range_m,
  input  logic [AW-1:0]       remap,
  output logic                hit,
  output logic [AW-1:0]       laddr
);
  logic [AW-1:0] diff;

  for (genvar i = 0; i < AW; i++) begin : g_bit
    if (i < DEC_LSB) begin : g_pass
      assign diff[i]  = 1'b0;
      assign laddr[i] = addr[i];
    end else begin : g_dec
      assign diff[i]  = range_m[i] & (addr[i] ^ base[i]);
      assign laddr[i] = range_m[i] ? remap[i] : addr[i];
    end
  end

  assign hit = en & ~(|diff);
endmodule

// File: rtl/aw_stage.sv
module aw_stage #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_hit,
  input  logic [AW-1:0] in_laddr,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_hit,
  output logic [AW-1:0] out_laddr
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hit   <= 1'b0;
      out_laddr <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_hit   <= in_hit;
        out_laddr <= in_laddr;
      end
    end
  end

  // R8: a stalled result stays put
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hit) && $stable(out_laddr)));

  // R8: an empty stage always takes input
  assert_empty_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R7: an accepted lookup is presented on the next edge
  assert_accept_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/addr_window_xlate.sv
module addr_window_xlate #(
  parameter int AW      = 32,
  parameter int DEC_LSB = 4,
  parameter int EN_BIT  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          lk_valid,
  output logic          lk_ready,
  input  logic [AW-1:0] lk_addr,
  output logic          rs_valid,
  input  logic          rs_ready,
  output logic          rs_hit,
  output logic [AW-1:0] rs_laddr
);
  logic [AW-1:DEC_LSB] base_q;
  logic                base_en;
  logic [AW-1:0]       range_q;
  logic [AW-1:0]       remap_q;
  logic                hit_d;
  logic [AW-1:0]       laddr_d;
  logic                accept;

  aw_regs #(.AW(AW), .DEC_LSB(DEC_LSB), .EN_BIT(EN_BIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .base_q(base_q), .base_en(base_en),
    .range_q(range_q), .remap_q(remap_q)
  );

  aw_match #(.AW(AW), .DEC_LSB(DEC_LSB)) u_match (
    .addr(lk_addr), .base(base_q), .en(base_en), .range_m(range_q),
    .remap(remap_q), .hit(hit_d), .laddr(laddr_d)
  );

  aw_stage #(.AW(AW)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(lk_valid), .in_ready(lk_ready),
    .in_hit(hit_d), .in_laddr(laddr_d), .out_valid(rs_valid),
    .out_ready(rs_ready), .out_hit(rs_hit), .out_laddr(rs_laddr)
  );

  assign accept = lk_valid && lk_ready;

  // R5: a disabled space yields a miss
  assert_disabled_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !base_en) |=> !rs_hit);

  // R4: any masked bit that differs from the base forces a miss
  assert_mismatch_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && ((lk_addr[AW-1:DEC_LSB] ^ base_q) & range_q[AW-1:DEC_LSB]) != '0) |=> !rs_hit);

  // R10: empty mask with the space on hits everything
  assert_open_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && base_en && range_q[AW-1:DEC_LSB] == '0) |=> rs_hit);

  // R6: low address bits pass through untouched
  assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rs_laddr[DEC_LSB-1:0] == $past(lk_addr[DEC_LSB-1:0])));
endmodule

// File: tb/addr_window_xlate_bench.sv
module addr_window_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        rs_valid;
  logic        rs_ready = 1'b1;
  logic        rs_hit;
  logic [31:0] rs_laddr;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_window_xlate u_addr_window_xlate (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
    .lk_ready(lk_ready), .lk_addr(lk_addr), .rs_valid(rs_valid),
    .rs_ready(rs_ready), .rs_hit(rs_hit), .rs_laddr(rs_laddr)
  );

  // behavioural reference
  logic [31:0] m_range, m_remap, m_desc, m_base;
  logic        m_en, m_valid, m_hit;
  logic [31:0] m_laddr;

  function automatic logic [31:0] m_read(input logic [1:0] s);
    case (s)
      2'd0: return (m_base & m_range & 32'hFFFF_FFF0) | (m_en ? 32'h2 : 32'h0);
      2'd1: return m_range;
      2'd2: return m_remap;
      default: return m_desc;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_range = 0; m_remap = 0; m_desc = 0; m_base = 0; m_en = 0;
      m_valid = 0; m_hit = 0; m_laddr = 0;
    end else begin
      if (!m_valid || rs_ready) begin
        if (lk_valid) begin
          logic [31:0] msk;
          msk     = m_range & 32'hFFFF_FFF0;
          m_valid = 1;
          m_hit   = m_en && (((lk_addr ^ m_base) & msk) == 0);
          m_laddr = (lk_addr & ~msk) | (m_remap & msk);
        end else m_valid = 0;
      end
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin m_base = reg_wdata & m_range & 32'hFFFF_FFF0; m_en = reg_wdata[1]; end
          2'd1: m_range = reg_wdata;
          2'd2: m_remap = reg_wdata;
          default: m_desc = reg_wdata;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 rs_valid", {31'd0, rs_valid}, {31'd0, m_valid});
      chk("R8 lk_ready", {31'd0, lk_ready}, {31'd0, (!m_valid || rs_ready)});
      chk("R2 reg_rdata", reg_rdata, m_read(reg_sel));
      if (m_valid) begin
        chk("R4 rs_hit", {31'd0, rs_hit}, {31'd0, m_hit});
        chk("R6 rs_laddr", rs_laddr, m_laddr);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1; reg_sel = s; reg_wdata = d;
    tick();
    reg_wr = 0;
  endtask

  task automatic look(input logic [31:0] a);
    lk_valid = 1; lk_addr = a;
    tick();
    lk_valid = 0;
  endtask

  task automatic rd(input logic [1:0] s, input string tag, input logic [31:0] exp);
    reg_sel = s; #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 rs_valid", {31'd0, rs_valid}, 32'd0);
    for (int s = 0; s < 4; s++) rd(s[1:0], "R1 reg after reset", 32'd0);

    // R3: sizing probe
    wreg(2'd1, 32'hFFFF_0000);
    wreg(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, "R3 sizing readback", 32'hFFFF_0002);
    wreg(2'd3, 32'h0000_00A5);
    rd(2'd3, "R2 descriptor", 32'h0000_00A5);

    // R4 / R6: enabled window
    wreg(2'd0, 32'h1234_0002);
    rd(2'd0, "R3 base readback", 32'h1234_0002);
    wreg(2'd2, 32'hABCD_0000);
    look(32'h1234_5678);
    chk("R4 hit inside", {31'd0, rs_hit}, 32'd1);
    chk("R6 remapped", rs_laddr, 32'hABCD_5678);
    look(32'h1235_5678);
    chk("R4 miss outside", {31'd0, rs_hit}, 32'd0);
    chk("R6 remap on miss", rs_laddr, 32'hABCD_5678);

    // R5: space disabled
    wreg(2'd0, 32'h1234_0000);
    look(32'h1234_5678);
    chk("R5 disabled miss", {31'd0, rs_hit}, 32'd0);

    // R8 / R9: stall, then rewrite remap behind a held result
    wreg(2'd0, 32'h1234_0002);
    rs_ready = 0;
    lk_valid = 1; lk_addr = 32'h1234_0010;
    tick();
    chk("R8 stalled ready low", {31'd0, lk_ready}, 32'd0);
    chk("R7 held laddr", rs_laddr, 32'hABCD_0010);
    lk_addr = 32'h9999_0000;
    reg_wr = 1; reg_sel = 2'd2; reg_wdata = 32'h5555_0000;
    tick();
    reg_wr = 0;
    chk("R9 held result unchanged", rs_laddr, 32'hABCD_0010);
    chk("R8 held hit", {31'd0, rs_hit}, 32'd1);
    rs_ready = 1;
    tick();
    lk_valid = 0;
    chk("R9 new regs used", rs_laddr, 32'h5555_0000);
    chk("R9 new lookup miss", {31'd0, rs_hit}, 32'd0);

    // R10: empty mask
    wreg(2'd1, 32'h0000_0000);
    look(32'hDEAD_BEEF);
    chk("R10 open hit", {31'd0, rs_hit}, 32'd1);
    chk("R10 open laddr", rs_laddr, 32'hDEAD_BEEF);
    tick();

    // mixed traffic, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      rs_ready = ($urandom % 4) != 0;
      lk_valid = ($urandom % 3) != 0;
      if ($urandom % 2) lk_addr = ($urandom & ~m_range) | (m_base & m_range) | ($urandom & 32'hF);
      else lk_addr = $urandom;
      reg_wr = ($urandom % 8) == 0;
      reg_sel = 2'($urandom);
      case ($urandom % 3)
        0: reg_wdata = 32'hFFF0_0000 | 32'($urandom % 4);
        1: reg_wdata = $urandom | 32'h2;
        default: reg_wdata = $urandom;
      endcase
      tick();
    end
    reg_wr = 0; lk_valid = 0; rs_ready = 1;
    tick();
    tick();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule